// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Converter Register Front End

This block is the digital front end of a two-channel 12-bit converter whose data arrives over an 8-bit bus. Each channel keeps a word in two input registers: an 8-bit low part and a 4-bit high part. Each channel also has a 12-bit output register that drives the converter code. A host writes the two parts of a word in either order, using a byte select and a channel select. A shared active-low load strobe decides when the output registers change.

There are two ways to use it. In automatic mode the host holds load low while it writes. The addressed channel's output register then follows its input registers, so the second byte of a word updates the output at once. In strobed mode load stays high while both channels are written. A later rising edge of load copies both channels' input registers into their output registers on the same clock. A separate active-low zero override clears every register asynchronously.

All bus and control pins are sampled on the system clock through a two-stage synchronizer. Level-sensitive behaviour is modelled as registers that load on each clock while their enable holds.

Top module: `dual_dac_regif`

## Requirements
- R1: With write low (`wr_ni`=0) and `byte_sel_i`=0, the selected channel's input word bits 7..0 take `data_i[7:0]`.
- R2: With write low and `byte_sel_i`=1, the selected channel's word bits 11..8 take `data_i[3:0]`. Bits `data_i[7:4]` have no effect.
- R3: The low and high parts of a word may be written in either order, and the final word is the same.
- R4: `chan_sel_i`=0 addresses channel A (`dac_a_o`) and `chan_sel_i`=1 addresses channel B (`dac_b_o`). The channel that is not addressed keeps its input and output registers.
- R5: While `wr_ni` is high, no input register changes, whatever the other pins do.
- R6: While `wr_ni` and `load_ni` are both low, the addressed channel's output takes the updated input word on the same clock as the input register. The other channel's output holds.
- R7: While `load_ni` stays high, outputs do not change. On a rising edge of `load_ni`, both outputs take their channel's input word on the same clock.
- R8: While `zero_ni` (or `rst_ni`) is low, all input and output registers are zero without waiting for a clock, and writes are ignored. After release with `wr_ni` high, the outputs stay zero.
- R9: A pin change reaches the outputs on the third rising clock edge after it is applied: two synchronizer stages plus the register.
- R10: If a write to one channel and a rising edge of `load_ni` are seen on the same clock, the transfer uses each channel's input word after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, released synchronously |
| zero_ni | input | 1 | Active-low zero override of all registers |
| data_i | input | 8 | Data bus |
| wr_ni | input | 1 | Active-low write enable |
| byte_sel_i | input | 1 | 0 = low 8 bits, 1 = high 4 bits |
| chan_sel_i | input | 1 | 0 = channel A, 1 = channel B |
| load_ni | input | 1 | Active-low load; rising edge transfers both channels |
| dac_a_o | output | 12 | Channel A output register |
| dac_b_o | output | 12 | Channel B output register |

## Verification
On every cycle, assertions check the following:
- input registers hold without an enabled write;
- byte lanes land in the correct word bits;
- outputs hold unless a transparent write or a transfer occurs, and equal the input word right after one;
- outputs are zero while the internal reset is low.

Only the bench's scenarios can show the rest. These are byte order independence, the three-edge latency, the equivalence of four-cycle automatic and five-cycle strobed updates, the post-write transfer on a coinciding strobe, and the asynchronous effect of the zero override between clock edges.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;
  typedef struct packed {
    logic load_n;
    logic wr_n;
    logic chan;
    logic bsel;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{load_n: 1'b1, wr_n: 1'b1, chan: 1'b0, bsel: 1'b0};
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int          W       = 8,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int BUS_W  = 8,
  parameter int WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  data_i,
  input  logic              wr_en_i,
  input  logic              bsel_i,
  input  logic              transp_i,
  input  logic              xfer_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int HI_W = WORD_W - BUS_W;

  logic [BUS_W-1:0]  lo_q, lo_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic [WORD_W-1:0] out_q;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr_en_i) begin
      if (bsel_i) hi_d = data_i[HI_W-1:0];
      else        lo_d = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      out_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      // transparent write or strobe both use post-write contents
      if (transp_i || xfer_i) out_q <= {hi_d, lo_d};
    end
  end

  assign word_o = out_q;

  a_r1_low_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !bsel_i) |=> lo_q == $past(data_i))
    else $error("R1 low lane");

  a_r2_high_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && bsel_i) |=> hi_q == $past(data_i[HI_W-1:0]))
    else $error("R2 high lane");

  a_r5_hold_inputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(lo_q) && $stable(hi_q)))
    else $error("R5 input hold");

  a_r7_hold_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(transp_i || xfer_i) |=> $stable(out_q))
    else $error("R7 output hold");

  a_r7_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> out_q == {hi_q, lo_q})
    else $error("R7 transfer");

  a_r6_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    transp_i |=> out_q == {hi_q, lo_q})
    else $error("R6 transparent");
endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
  import dac_regif_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int WORD_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zero_ni,
  input  logic [BUS_W-1:0]  data_i,
  input  logic              wr_ni,
  input  logic              byte_sel_i,
  input  logic              chan_sel_i,
  input  logic              load_ni,
  output logic [WORD_W-1:0] dac_a_o,
  output logic [WORD_W-1:0] dac_b_o
);
  localparam int CTRL_W = $bits(ctrl_t);
  localparam int SYNC_W = CTRL_W + BUS_W;
  localparam int NUM_CH = 2;
  localparam logic [SYNC_W-1:0] SYNC_RST = {CTRL_IDLE, {BUS_W{1'b0}}};

  logic              rst_n;
  ctrl_t             ctrl_in, ctrl_s;
  logic [SYNC_W-1:0] sync_q;
  logic [BUS_W-1:0]  data_s;
  logic              load_prev_q;
  logic              xfer;
  logic [WORD_W-1:0] word [NUM_CH];

  dac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .arst_ni(rst_ni & zero_ni),
    .rst_no (rst_n)
  );

  assign ctrl_in = '{load_n: load_ni, wr_n: wr_ni, chan: chan_sel_i, bsel: byte_sel_i};

  dac_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   ({ctrl_in, data_i}),
    .q_o   (sync_q)
  );

  assign ctrl_s = ctrl_t'(sync_q[SYNC_W-1 -: CTRL_W]);
  assign data_s = sync_q[BUS_W-1:0];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) load_prev_q <= 1'b1;
    else        load_prev_q <= ctrl_s.load_n;
  end

  assign xfer = ctrl_s.load_n & ~load_prev_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic wr_en, transp;
    assign wr_en  = ~ctrl_s.wr_n & (ctrl_s.chan == 1'(ch));
    assign transp = wr_en & ~ctrl_s.load_n;

    dac_chan #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .data_i  (data_s),
      .wr_en_i (wr_en),
      .bsel_i  (ctrl_s.bsel),
      .transp_i(transp),
      .xfer_i  (xfer),
      .word_o  (word[ch])
    );
  end

  assign dac_a_o = word[0];
  assign dac_b_o = word[1];

  always @(posedge clk_i) begin
    if (!rst_n) begin
      a_r8_zero_override: assert (dac_a_o == '0 && dac_b_o == '0)
        else $error("R8 zero override");
    end
  end
endmodule

// File: tb/tb_dual_dac_regif.sv
`timescale 1ns/1ps
module tb_dual_dac_regif;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        zero_ni = 1'b1;
  logic [7:0]  data_i = '0;
  logic        wr_ni = 1'b1;
  logic        byte_sel_i = 1'b0;
  logic        chan_sel_i = 1'b0;
  logic        load_ni = 1'b1;
  logic [11:0] dac_a_o, dac_b_o;

  always #2 clk_i = ~clk_i;

  dual_dac_regif dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .zero_ni(zero_ni), .data_i(data_i),
    .wr_ni(wr_ni), .byte_sel_i(byte_sel_i), .chan_sel_i(chan_sel_i),
    .load_ni(load_ni), .dac_a_o(dac_a_o), .dac_b_o(dac_b_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0]  m_lo [2];
  logic [3:0]  m_hi [2];
  logic [11:0] m_out [2];
  logic        m_load_n = 1'b1;

  function automatic logic [11:0] m_word(int ch);
    return {m_hi[ch], m_lo[ch]};
  endfunction

  function automatic logic [11:0] dut_out(int ch);
    return (ch == 0) ? dac_a_o : dac_b_o;
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_both(string req);
    check({req, " ch A"}, dac_a_o, m_out[0]);
    check({req, " ch B"}, dac_b_o, m_out[1]);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin m_lo[c] = '0; m_hi[c] = '0; m_out[c] = '0; end
  endtask

  // starts and ends on a falling edge
  task automatic write(int ch, bit b, logic [7:0] d);
    chan_sel_i = ch[0]; byte_sel_i = b; data_i = d; wr_ni = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    wr_ni = 1'b1; data_i = $urandom;
    if (b) m_hi[ch] = d[3:0]; else m_lo[ch] = d;
    if (!m_load_n) m_out[ch] = m_word(ch);
  endtask

  task automatic set_load(bit lv);
    load_ni = lv;
    if (!m_load_n && lv) for (int c = 0; c < 2; c++) m_out[c] = m_word(c);
    m_load_n = lv;
    idle(1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h0dac_5eed));
    model_clear();
    idle(3);
    check_both("R8 reset state");
    rst_ni = 1'b1;
    idle(4);
    check_both("R8 after reset release");

    // R1/R2/R7 strobed: writes with load high leave outputs alone
    write(0, 0, 8'hA5); write(0, 1, 8'hF3);
    write(1, 1, 8'h0C); write(1, 0, 8'h5A);
    idle(4);
    check_both("R7 no change while load high");
    set_load(0); set_load(1); idle(4);
    check_both("R7 strobe updates both");
    check("R2 upper nibble ignored", dac_a_o, 12'h3A5);
    check("R1 low byte", dac_b_o, 12'hC5A);

    // R3: opposite order gives the same word
    write(1, 0, 8'hA5); write(1, 1, 8'h03);
    set_load(0); set_load(1); idle(4);
    check("R3 order independent", dac_b_o, dac_a_o);

    // R5: strobes toggling with write high change nothing
    chan_sel_i = 1'b1; byte_sel_i = 1'b1; data_i = 8'hFF; idle(2);
    chan_sel_i = 1'b0; byte_sel_i = 1'b0; data_i = 8'h00; idle(2);
    set_load(0); set_load(1); idle(4);
    check_both("R5 write high holds");

    // R6/R9 automatic: latency of three edges
    set_load(0); idle(3);
    chan_sel_i = 1'b0; byte_sel_i = 1'b0; data_i = 8'h11; wr_ni = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    wr_ni = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    check("R9 unchanged after two edges", dac_a_o, m_out[0]);
    m_lo[0] = 8'h11; m_out[0] = m_word(0);
    @(posedge clk_i); @(negedge clk_i);
    check("R9 updated on third edge", dac_a_o, m_out[0]);
    check("R6 other channel holds", dac_b_o, m_out[1]);
    idle(3);

    // R6 four-cycle automatic update of both channels
    write(0, 0, 8'h12); write(0, 1, 8'h04);
    write(1, 1, 8'h0B); write(1, 0, 8'hCD);
    idle(4);
    check_both("R6 automatic four-cycle update");
    check("R4 channel A word", dac_a_o, 12'h412);
    check("R4 channel B word", dac_b_o, 12'hBCD);
    set_load(1); idle(4);

    // R10: write to B coinciding with a load rising edge
    write(0, 0, 8'h77);
    set_load(0);
    chan_sel_i = 1'b1; byte_sel_i = 1'b0; data_i = 8'h99; wr_ni = 1'b0; load_ni = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    wr_ni = 1'b1;
    m_lo[1] = 8'h99; m_load_n = 1'b1;
    for (int c = 0; c < 2; c++) m_out[c] = m_word(c);
    idle(4);
    check_both("R10 transfer uses post-write data");

    // R8 zero override: asynchronous clear, writes ignored, stays zero
    write(0, 1, 8'h0E); write(1, 1, 8'h0D);
    #1 zero_ni = 1'b0;
    #0.5;
    model_clear();
    check_both("R8 async clear");
    @(negedge clk_i);
    write(0, 0, 8'hEE);
    m_lo[0] = '0;
    zero_ni = 1'b1;
    idle(5);
    check_both("R8 zeros stay latched");
    set_load(0); set_load(1); idle(4);
    check_both("R8 strobe after release moves zeros");

    // random mix of writes and load activity
    for (int i = 0; i < 80; i++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      if (op < 7) write(int'($urandom_range(0, 1)), 1'($urandom), 8'($urandom));
      else if (op == 7) set_load(~m_load_n);
      else if (m_load_n) begin set_load(0); set_load(1); end
      idle(4);
      check_both("R4 R6 R7 random");
    end

    summary();
    $finish;
  end
endmodule